// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is a serial peripheral interface master controlled through a single register-write port. Each write carries a one-bit address and a 32-bit word. Address 0 loads the configuration word and address 1 loads the data word. The configuration word holds the mode flags, the transfer length (1 to 32 bits), the SCLK divider (2 to 257 reference cycles per bit) and the chip-select field.

Loading the data word starts a transfer. The transfer has a fixed duration that software can predict from the configuration alone, so the next command can be scheduled to the cycle. When capture is enabled, the block returns the received bits right-aligned on a data output with a one-cycle valid strobe, in the first cycle after the transfer ends. A command that arrives while a transfer runs is neither queued nor allowed to disturb the running transfer. It is dropped and raises a sticky error flag.

Top module: `spi_bus_master`

## Requirements
- R1: Configuration word layout: bits [31:24] chip-select field, [23:16] divider minus 2 (D = field + 2, 2..257), [12:8] length minus 1 (L = field + 1, 1..32; bits [15:13] unused), [7:0] flags. Flag bits: 0 offline, 1 end (release chip-select after the transfer), 2 capture, 3 chip-select polarity, 4 clock polarity, 5 clock phase, 6 LSB-first, 7 half-duplex. After reset all fields are 0, giving L = 1 and D = 2.
- R2: A data write at address 1, presented in cycle 0 while idle, starts a transfer. busy_o is high in cycles 1 through (L+1)·D, and the next command may be presented in cycle (L+1)·D+1.
- R3: Any write, configuration or data, presented while busy_o is high is dropped and sets err_o. err_o stays set until reset.
- R4: With flag bit 6 clear, MOSI sends wr_data[31] first, then the lower bits in descending order, for L bits. The first received bit lands at rd_data_o[L-1], and all bits above L-1 read 0.
- R5: With flag bit 6 set, MOSI sends wr_data[0] first, then the higher bits in ascending order. The first received bit lands at rd_data_o[0], with the result right-aligned to L bits.
- R6: With capture set, rd_valid_o pulses high for exactly one cycle, in the cycle busy_o falls, and rd_data_o carries the received word. With capture clear, there is no pulse and rd_data_o keeps its previous value.
- R7: SCLK idles at the clock-polarity flag. Each of the first L slots of D cycles spends floor(D/2) cycles idle and then the remaining cycles active. The final slot stays idle, so SCLK makes exactly 2·L transitions per transfer.
- R8: With clock phase 0, MOSI changes at the start of each slot and input is sampled on the idle-to-active edge. With clock phase 1, MOSI changes on the idle-to-active edge and input is sampled on the next active-to-idle edge. A loopback of MOSI to MISO returns the sent bits in both phases.
- R9: With half-duplex set, MISO is ignored and input bits are taken from mosi_i. With half-duplex and capture both set, mosi_oe_o is low.
- R10: Chip-select is asserted from cycle 1. cs_o shows the low CS_W bits of the chip-select field, inverted when the polarity flag is clear and unchanged when it is set. With end set, the lines return to inactive in the cycle busy_o falls. With end clear, they stay asserted.
- R11: With offline set, drive_en_o and mosi_oe_o are both low.
- R12: After reset, busy_o, err_o, rd_valid_o and sclk_o are 0, cs_o is all ones, rd_data_o is 0, and drive_en_o and mosi_oe_o are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration, 1 = data |
| wr_data | input | 32 | Write word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for the MOSI pad |
| mosi_i | input | 1 | MOSI pad input (half-duplex receive) |
| miso_i | input | 1 | Serial data in |
| cs_o | output | CS_W | Chip-select lines |
| drive_en_o | output | 1 | Bus pads driven when high |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Sticky dropped-command flag |
| rd_valid_o | output | 1 | One-cycle strobe for captured data |
| rd_data_o | output | 32 | Captured word, right-aligned |

## Verification
The end of one transfer and the acceptance of the next data write can fall in the same cycle. In that cycle, busy_o drops, rd_valid_o pulses and chip-select is released. The bench provokes this by presenting a new data write in exactly the cycle it first sees busy_o low. It then judges the outcome in three ways: err_o must stay clear, the second transfer must run for its full (L+1)·D cycles, and rd_data_o must first carry the first word and then the second.

// File: rtl/spi_bus_master_pkg.sv
`timescale 1ns/1ps
package spi_bus_master_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 6;   // holds 0..32
    localparam int DIV_W  = 9;   // holds 2..257

    // Laid out to match the configuration word bit for bit.
    typedef struct packed {
        logic [7:0] cs_field;
        logic [7:0] div_m2;
        logic [7:0] len_m1;
        logic       half_duplex;
        logic       lsb_first;
        logic       cpha;
        logic       cpol;
        logic       cs_pol;
        logic       capture;
        logic       end_xfer;
        logic       offline;
    } cfg_t;
endpackage

// File: rtl/spi_slot_timer.sv
`timescale 1ns/1ps
module spi_slot_timer #(
    parameter int LEN_W = 6,
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             run_o,
    output logic             lead_o,
    output logic             trail_o,
    output logic             first_o,
    output logic             last_o,
    output logic             active_d_o,
    output logic             done_o
);
    typedef struct packed {
        logic             run;
        logic [LEN_W-1:0] slot;
        logic [DIV_W-1:0] pos;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        half = div_i >> 1;
        st_d = st_q;
        if (start_i && !st_q.run) begin
            st_d.run  = 1'b1;
            st_d.slot = '0;
            st_d.pos  = '0;
        end else if (st_q.run) begin
            if (st_q.pos == div_i - 1'b1) begin
                st_d.pos = '0;
                if (st_q.slot == len_i) st_d.run  = 1'b0;
                else                    st_d.slot = st_q.slot + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        lead_o     = st_d.run && (st_d.slot < len_i) && (st_d.pos == half);
        trail_o    = st_d.run && (st_d.pos == '0) && (st_d.slot != '0);
        first_o    = (st_d.slot == '0);
        last_o     = (st_d.slot == len_i);
        active_d_o = st_d.run && (st_d.slot < len_i) && (st_d.pos >= half);
        done_o     = st_q.run && !st_d.run;
        run_o      = st_q.run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_shift_unit.sv
`timescale 1ns/1ps
module spi_shift_unit #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              lsb_i,
    input  logic              cpha_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              lead_i,
    input  logic              trail_i,
    input  logic              first_i,
    input  logic              last_i,
    input  logic              in_bit_i,
    output logic              out_bit_o,
    output logic [WORD_W-1:0] rx_word_o
);
    localparam int SH_W = $clog2(WORD_W) + 1;

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_t;

    sh_t st_d, st_q;
    logic shift_tx, sample;
    logic [SH_W-1:0] shamt;

    always_comb begin
        shift_tx = cpha_i ? (lead_i && !first_i) : (trail_i && !last_i);
        sample   = cpha_i ? trail_i : lead_i;
        st_d     = st_q;
        if (load_i) begin
            st_d.tx = data_i;
            st_d.rx = '0;
        end else begin
            if (shift_tx)
                st_d.tx = lsb_i ? (st_q.tx >> 1) : (st_q.tx << 1);
            if (sample)
                st_d.rx = lsb_i ? {in_bit_i, st_q.rx[WORD_W-1:1]}
                                : {st_q.rx[WORD_W-2:0], in_bit_i};
        end
        out_bit_o = lsb_i ? st_q.tx[0] : st_q.tx[WORD_W-1];
        shamt     = SH_W'(WORD_W) - SH_W'(len_i);
        rx_word_o = lsb_i ? (st_q.rx >> shamt) : st_q.rx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_pin_ctrl.sv
`timescale 1ns/1ps
module spi_pin_ctrl #(
    parameter int CS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_d_i,
    input  logic            cpol_i,
    input  logic            cs_pol_i,
    input  logic [CS_W-1:0] cs_sel_i,
    input  logic            cs_set_i,
    input  logic            cs_clr_i,
    input  logic            offline_i,
    input  logic            half_i,
    input  logic            capture_i,
    output logic            sclk_o,
    output logic [CS_W-1:0] cs_o,
    output logic            drive_en_o,
    output logic            mosi_oe_o
);
    typedef struct packed {
        logic sclk_act;
        logic cs_act;
    } pin_t;

    pin_t st_d, st_q;
    logic [CS_W-1:0] mask;

    always_comb begin
        st_d          = st_q;
        st_d.sclk_act = active_d_i;
        if (cs_set_i)      st_d.cs_act = 1'b1;
        else if (cs_clr_i) st_d.cs_act = 1'b0;
        mask       = st_q.cs_act ? cs_sel_i : '0;
        cs_o       = cs_pol_i ? mask : ~mask;
        sclk_o     = st_q.sclk_act ^ cpol_i;
        drive_en_o = !offline_i;
        mosi_oe_o  = !offline_i && !(half_i && capture_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_bus_master.sv
`timescale 1ns/1ps
module spi_bus_master
    import spi_bus_master_pkg::*;
#(
    parameter int CS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [31:0]       wr_data,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic [CS_W-1:0]   cs_o,
    output logic              drive_en_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o
);
    typedef struct packed {
        cfg_t              cfg;
        logic              err;
        logic              valid;
        logic [WORD_W-1:0] rdata;
    } top_t;

    top_t st_d, st_q;

    logic              run, lead, trail, first, last, active_d, done;
    logic              start, cfg_we, in_bit;
    logic [LEN_W-1:0]  len;
    logic [DIV_W-1:0]  div;
    logic [WORD_W-1:0] rx_word;

    always_comb begin
        len    = LEN_W'(st_q.cfg.len_m1[4:0]) + 1'b1;
        div    = DIV_W'(st_q.cfg.div_m2) + 2'd2;
        start  = wr_en && wr_addr && !run;
        cfg_we = wr_en && !wr_addr && !run;
        in_bit = st_q.cfg.half_duplex ? mosi_i : miso_i;

        st_d       = st_q;
        st_d.err   = st_q.err || (wr_en && run);
        st_d.valid = done && st_q.cfg.capture;
        if (cfg_we) st_d.cfg = cfg_t'(wr_data);
        if (done && st_q.cfg.capture) st_d.rdata = rx_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    spi_slot_timer #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .len_i      (len),
        .div_i      (div),
        .run_o      (run),
        .lead_o     (lead),
        .trail_o    (trail),
        .first_o    (first),
        .last_o     (last),
        .active_d_o (active_d),
        .done_o     (done)
    );

    spi_shift_unit #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start),
        .data_i    (wr_data),
        .lsb_i     (st_q.cfg.lsb_first),
        .cpha_i    (st_q.cfg.cpha),
        .len_i     (len),
        .lead_i    (lead),
        .trail_i   (trail),
        .first_i   (first),
        .last_i    (last),
        .in_bit_i  (in_bit),
        .out_bit_o (mosi_o),
        .rx_word_o (rx_word)
    );

    spi_pin_ctrl #(.CS_W(CS_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_d_i (active_d),
        .cpol_i     (st_q.cfg.cpol),
        .cs_pol_i   (st_q.cfg.cs_pol),
        .cs_sel_i   (st_q.cfg.cs_field[CS_W-1:0]),
        .cs_set_i   (start),
        .cs_clr_i   (done && st_q.cfg.end_xfer),
        .offline_i  (st_q.cfg.offline),
        .half_i     (st_q.cfg.half_duplex),
        .capture_i  (st_q.cfg.capture),
        .sclk_o     (sclk_o),
        .cs_o       (cs_o),
        .drive_en_o (drive_en_o),
        .mosi_oe_o  (mosi_oe_o)
    );

    assign busy_o     = run;
    assign err_o      = st_q.err;
    assign rd_valid_o = st_q.valid;
    assign rd_data_o  = st_q.rdata;
endmodule

// File: rtl/spi_bus_master_chk.sv
`timescale 1ns/1ps
module spi_bus_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_addr,
    input logic [31:0] wr_data,
    input logic        busy_o,
    input logic        err_o,
    input logic        rd_valid_o,
    input logic        sclk_o
);
    logic [15:0] exp_q, cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= 16'd4;
            cnt_q <= '0;
        end else begin
            if (wr_en && !wr_addr && !busy_o)
                exp_q <= (16'(wr_data[12:8]) + 16'd2) * (16'(wr_data[23:16]) + 16'd2);
            cnt_q <= busy_o ? cnt_q + 1'b1 : '0;
        end
    end

    p_dur_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (cnt_q == exp_q));
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wr_en && wr_addr));
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy_o) |=> err_o);
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);
    p_valid_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $fell(busy_o));
    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o) && !$past(wr_en)) |-> $stable(sclk_o));
endmodule

bind spi_bus_master spi_bus_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy_o     (busy_o),
    .err_o      (err_o),
    .rd_valid_o (rd_valid_o),
    .sclk_o     (sclk_o)
);

// File: tb/tb_spi_bus_master.sv
`timescale 1ns/1ps
module tb_spi_bus_master;
    localparam int CS_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            wr_en = 1'b0, wr_addr = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            sclk_o, mosi_o, mosi_oe_o, mosi_i, miso_i;
    logic [CS_W-1:0] cs_o;
    logic            drive_en_o, busy_o, err_o, rd_valid_o;
    logic [31:0]     rd_data_o;
    logic            loop_en = 1'b1, miso_force = 1'b0, mosi_drive = 1'b0;

    assign miso_i = loop_en ? mosi_o : miso_force;
    assign mosi_i = mosi_drive;

    spi_bus_master #(.CS_W(CS_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .mosi_i(mosi_i),
        .miso_i(miso_i), .cs_o(cs_o), .drive_en_o(drive_en_o), .busy_o(busy_o),
        .err_o(err_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] data;
        logic [31:0] exp;
        logic [31:0] dur;
        logic [31:0] tog;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{32'h01020706, 32'hA5000000, 32'h000000A5, 32'd36,  32'd16},
        '{32'h01010746, 32'h000000C3, 32'h000000C3, 32'd27,  32'd16},
        '{32'h01001F26, 32'h12345678, 32'h12345678, 32'd66,  32'd64},
        '{32'h01FF0076, 32'h00000001, 32'h00000001, 32'd514, 32'd2},
        '{32'h01030416, 32'hF8000000, 32'h0000001F, 32'd30,  32'd10},
        '{32'h01050F66, 32'h0000BEEF, 32'h0000BEEF, 32'd119, 32'd32}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Called and returns at a falling edge.
    task automatic wr(input logic addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Presents a data write now; returns in the first idle cycle.
    task automatic run_xfer(input logic [31:0] data, output int cnt, output int tog,
                            output logic [CS_W-1:0] cs_mid, output logic oe_mid);
        logic prev;
        prev = sclk_o;
        cnt = 0; tog = 0; cs_mid = '0; oe_mid = 1'b0;
        wr(1'b1, data);
        cs_mid = cs_o;
        oe_mid = mosi_oe_o;
        while (busy_o) begin
            cnt++;
            if (sclk_o !== prev) tog++;
            prev = sclk_o;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt, tog;
        logic [CS_W-1:0] csm;
        logic oem;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 busy", busy_o, 0);
        chk("R12 err", err_o, 0);
        chk("R12 valid", rd_valid_o, 0);
        chk("R12 cs", cs_o, 8'hFF);
        chk("R12 sclk", sclk_o, 0);
        chk("R12 rd_data", rd_data_o, 0);
        chk("R12 drive_en", drive_en_o, 1);
        chk("R12 mosi_oe", mosi_oe_o, 1);

        // R1 R2 R4 R5 R7 R8 R10 vector table
        for (int i = 0; i < 6; i++) begin
            wr(1'b0, VEC[i].cfg);
            run_xfer(VEC[i].data, cnt, tog, csm, oem);
            chk("R2 duration", cnt, VEC[i].dur);
            chk("R7 sclk transitions", tog, VEC[i].tog);
            chk("R7 sclk idle level", sclk_o, VEC[i].cfg[4]);
            chk("R6 valid strobe", rd_valid_o, 1);
            chk("R4 R5 R8 received word", rd_data_o, VEC[i].exp);
            chk("R10 cs asserted", csm, 8'hFE);
            chk("R10 cs released", cs_o, 8'hFF);
            @(negedge clk);
            chk("R6 single pulse", rd_valid_o, 0);
        end

        // R2 back-to-back: next write in the first idle cycle
        wr(1'b0, 32'h01020706);
        run_xfer(32'hA5000000, cnt, tog, csm, oem);
        chk("R2 first word", rd_data_o, 32'hA5);
        run_xfer(32'h3C000000, cnt, tog, csm, oem);
        chk("R2 boundary write accepted", err_o, 0);
        chk("R2 boundary duration", cnt, 36);
        chk("R2 second word", rd_data_o, 32'h3C);

        // R6 capture clear: no strobe, data held
        wr(1'b0, 32'h01000702);
        run_xfer(32'hFF000000, cnt, tog, csm, oem);
        chk("R6 no strobe", rd_valid_o, 0);
        chk("R6 data held", rd_data_o, 32'h3C);

        // R9 half duplex
        loop_en = 1'b0; miso_force = 1'b0; mosi_drive = 1'b1;
        wr(1'b0, 32'h01000786);
        run_xfer(32'h00000000, cnt, tog, csm, oem);
        chk("R9 oe released", oem, 0);
        chk("R9 input from mosi_i", rd_data_o, 32'hFF);
        miso_force = 1'b1; mosi_drive = 1'b0;
        run_xfer(32'hFF000000, cnt, tog, csm, oem);
        chk("R9 miso ignored", rd_data_o, 32'h00);
        wr(1'b0, 32'h01000782);
        run_xfer(32'h00000000, cnt, tog, csm, oem);
        chk("R9 write-only drives", oem, 1);
        loop_en = 1'b1;

        // R10 polarity high and hold without end
        wr(1'b0, 32'h0500030E);
        run_xfer(32'h50000000, cnt, tog, csm, oem);
        chk("R10 active-high cs", csm, 8'h05);
        chk("R10 active-high release", cs_o, 8'h00);
        wr(1'b0, 32'h01000304);
        run_xfer(32'h50000000, cnt, tog, csm, oem);
        repeat (3) @(negedge clk);
        chk("R10 held without end", cs_o, 8'hFE);
        wr(1'b0, 32'h01000306);
        run_xfer(32'h50000000, cnt, tog, csm, oem);
        chk("R10 released with end", cs_o, 8'hFF);

        // R11 offline
        wr(1'b0, 32'h00000001);
        chk("R11 drive_en", drive_en_o, 0);
        chk("R11 mosi_oe", mosi_oe_o, 0);

        // R3 commands while busy
        wr(1'b0, 32'h01020706);
        chk("R3 err clear before", err_o, 0);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'hA5000000;
        @(negedge clk);
        wr_en = 1'b0;
        cnt = 0;
        while (busy_o) begin
            cnt++;
            if (cnt == 3) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h5A000000;
            end else if (cnt == 4) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h01000000;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        chk("R3 duration undisturbed", cnt, 36);
        chk("R3 data write dropped", rd_data_o, 32'hA5);
        chk("R3 err set", err_o, 1);
        run_xfer(32'hC3000000, cnt, tog, csm, oem);
        chk("R3 config write dropped", cnt, 36);
        chk("R3 word after drop", rd_data_o, 32'hC3);
        chk("R3 err sticky", err_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule